// File: doc/BRIEF.md
# Disc Playback Mode Sequencer

This block is the transport and play-order controller of a compact-disc player. Decoded button or infrared commands reach it as one-cycle strobes. It answers with the number of the track that the servo and decoder should play, a stop / play / pause transport state, and indicator flags for the display. It keeps a small programmed track list and a free-running pseudo-random source. Four play orders are built in: plain disc order, single-track repeat, whole-disc repeat and random play. A fixed priority decides which order wins when more than one is active.

The sequencer does not scan keys, decode remote frames, seek or drive the display. A track-ended event from the decoder moves it to the next track. The disc's track count comes in as a plain level. Two held inputs request fast scanning forward or backward. These pass through only while a track is loaded. All outputs except the scan pair are registered, so they change on the clock edge after the strobe that caused them.

Command strobes are expected one at a time. If several arrive in the same cycle, they resolve in this order: stop, play/pause, next, previous, track-ended, program entry. Repeat, random and clear always act alongside whichever of these wins.

Top module: `cd_mode_sequencer`

## Requirements
- R1: After reset the transport is stopped (`xport_state` 00), `req_track` is 1, both repeat flags are 0, `ind_random_n` is 1, and `ind_prog`, `prog_full` and `ind_play` are 0.
- R2: `cmd_play` toggles between play (01) and pause (10) while a track is loaded. From stop it enters play, unless `disc_tracks` is 0, in which case it is ignored. `ind_play` is 1 only in play.
- R3: `cmd_stop` puts the transport in stop (00) from play or pause. The track number and the programmed list are left as they were.
- R4: `cmd_next` / `cmd_prev` step the track by one in disc order, wrapping from `disc_tracks` to 1 and from 1 to `disc_tracks`. This applies always in stop, and in play or pause when neither a list nor random mode is active.
- R5: `track_end` acts only in play; in stop or pause it changes nothing. In disc order it advances the track by one. At the last track with repeat off, the transport goes to stop with `req_track` set to 1.
- R6: `cmd_repeat` cycles off, then single (`ind_rpt_one`), then whole disc (`ind_rpt_all`), then back to off. With single repeat, `track_end` keeps the same track. With whole-disc repeat, the end of the last track wraps to track 1 and play continues.
- R7: `cmd_prog` in stop appends the current track to the list, which holds up to 16 entries. An entry attempted while 16 are stored is dropped and sets `prog_full`, which stays set until `cmd_clear`. `cmd_clear` empties the list. `ind_prog` is 1 while the list holds any entry.
- R8: With a non-empty list and random mode off, play starts at list entry one. `next` and `prev` move through the list and wrap at its ends. `track_end` on the last entry goes to stop with track 1, or, with whole-disc repeat, wraps to the first entry.
- R9: `cmd_random` toggles random mode; `ind_random_n` is 0 while it is on. In random mode, starting play, `next` and `track_end` draw a track in 1..`disc_tracks` from a 16-bit LFSR. A draw that equals the current track is redrawn once from another slice of the LFSR. Play never stops at a track end. `prev` restarts the current track. Random order takes precedence over the list.
- R10: `scan_fwd` / `scan_rev` follow `hold_fwd` / `hold_rev` while the transport is in play or pause, provided only one of the two is held. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_play | input | 1 | Play/pause strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_next | input | 1 | Next-track strobe |
| cmd_prev | input | 1 | Previous-track strobe |
| cmd_repeat | input | 1 | Repeat-mode cycle strobe |
| cmd_prog | input | 1 | Program-entry strobe |
| cmd_clear | input | 1 | Program-clear strobe |
| cmd_random | input | 1 | Random-mode toggle strobe |
| hold_fwd | input | 1 | Fast-forward held |
| hold_rev | input | 1 | Fast-reverse held |
| track_end | input | 1 | Current track finished |
| disc_tracks | input | TW | Number of tracks on the disc |
| req_track | output | TW | Requested track number |
| xport_state | output | 2 | 00 stop, 01 play, 10 pause |
| ind_play | output | 1 | Play indicator |
| ind_prog | output | 1 | Program list non-empty |
| ind_rpt_one | output | 1 | Single-track repeat active |
| ind_rpt_all | output | 1 | Whole-disc repeat active |
| ind_random_n | output | 1 | Random indicator, low while random is on |
| prog_full | output | 1 | Entry dropped on a full list |
| scan_fwd | output | 1 | Fast-forward scan request |
| scan_rev | output | 1 | Fast-reverse scan request |

## Verification
A corrupted list index or list count shows on `req_track` at the next `next`, `prev` or `track_end`: the wrong entry appears, or the wrap point comes at the wrong place. A wrong repeat or random register shows within one cycle on the indicator flags. It also shows at the very next track end, as a stop where play should continue, or as a changed track where single repeat should hold it. The directed tasks therefore walk each play order across its wrap or stop boundary and sample the track and state one cycle after each strobe.

// File: rtl/cdseq_pkg.sv
package cdseq_pkg;
  typedef enum logic [1:0] {
    XP_STOP  = 2'b00,
    XP_PLAY  = 2'b01,
    XP_PAUSE = 2'b10
  } xport_e;

  typedef enum logic [1:0] {
    RP_OFF = 2'd0,
    RP_ONE = 2'd1,
    RP_ALL = 2'd2
  } rpt_e;
endpackage

// File: rtl/cdseq_lfsr.sv
module cdseq_lfsr #(
  parameter int LW = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [LW-1:0] rnd
);
  // Galois form, advanced every cycle so the draw depends on command timing
  always_ff @(posedge clk) begin
    if (!rst_n) rnd <= SEED;
    else if (rnd[0]) rnd <= (rnd >> 1) ^ TAPS;
    else rnd <= rnd >> 1;
  end
endmodule

// File: rtl/cdseq_pick.sv
module cdseq_pick #(
  parameter int TW = 8,
  parameter int LW = 16
) (
  input  logic [LW-1:0] rnd,
  input  logic [TW-1:0] ntracks,
  input  logic [TW-1:0] cur,
  output logic [TW-1:0] pick
);
  localparam int HW = LW / 2;

  logic [LW-1:0] div;
  logic [LW-1:0] rot;
  logic [TW-1:0] first;
  logic [TW-1:0] second;

  always_comb begin
    div    = (ntracks == '0) ? LW'(1) : LW'(ntracks);
    rot    = {rnd[HW-1:0], rnd[LW-1:HW]};
    first  = TW'(rnd % div) + TW'(1);
    second = TW'(rot % div) + TW'(1);
    if (ntracks == '0)     pick = TW'(1);
    else if (first == cur) pick = second;   // one redraw from the swapped halves
    else                   pick = first;
  end
endmodule

// File: rtl/cdseq_playlist.sv
module cdseq_playlist #(
  parameter int TW    = 8,
  parameter int DEPTH = 16,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          clr,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [TW-1:0] rd_data [NRD],
  output logic [CW-1:0] count,
  output logic          full_flag
);
  logic [TW-1:0] mem [DEPTH];
  logic          at_cap;

  assign at_cap = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      full_flag <= 1'b0;
    end else if (clr) begin
      count     <= '0;
      full_flag <= 1'b0;
    end else if (wr_en) begin
      if (at_cap) full_flag <= 1'b1;
      else        count     <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr && !at_cap) mem[count[AW-1:0]] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/cd_mode_sequencer.sv
module cd_mode_sequencer
  import cdseq_pkg::*;
#(
  parameter int TW    = 8,
  parameter int DEPTH = 16,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_play,
  input  logic          cmd_stop,
  input  logic          cmd_next,
  input  logic          cmd_prev,
  input  logic          cmd_repeat,
  input  logic          cmd_prog,
  input  logic          cmd_clear,
  input  logic          cmd_random,
  input  logic          hold_fwd,
  input  logic          hold_rev,
  input  logic          track_end,
  input  logic [TW-1:0] disc_tracks,
  output logic [TW-1:0] req_track,
  output logic [1:0]    xport_state,
  output logic          ind_play,
  output logic          ind_prog,
  output logic          ind_rpt_one,
  output logic          ind_rpt_all,
  output logic          ind_random_n,
  output logic          prog_full,
  output logic          scan_fwd,
  output logic          scan_rev
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  xport_e        st;
  rpt_e          rpt;
  logic          rnd_on;
  logic [TW-1:0] trk;
  logic [AW-1:0] pidx;

  logic [CW-1:0] count;
  logic          full;
  logic          prog_on;
  logic [AW-1:0] last_idx, pidx_inc, pidx_dec;
  logic [AW-1:0] rd_addr [3];
  logic [TW-1:0] rd_data [3];
  logic [TW-1:0] disc_inc, disc_dec;
  logic [LW-1:0] rnd;
  logic [TW-1:0] pick;
  logic          loaded;

  always_comb begin
    prog_on  = (count != '0);
    last_idx = AW'(count - CW'(1));
    pidx_inc = (pidx == last_idx) ? '0 : pidx + AW'(1);
    pidx_dec = (pidx == '0) ? last_idx : pidx - AW'(1);
    disc_inc = (trk >= disc_tracks) ? TW'(1) : trk + TW'(1);
    if (disc_tracks == '0)  disc_dec = trk;
    else if (trk <= TW'(1)) disc_dec = disc_tracks;
    else                    disc_dec = trk - TW'(1);
    rd_addr[0] = '0;
    rd_addr[1] = pidx_inc;
    rd_addr[2] = pidx_dec;
    loaded     = (st != XP_STOP);
  end

  cdseq_playlist #(.TW(TW), .DEPTH(DEPTH), .NRD(3)) u_list (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmd_prog && st == XP_STOP), .wr_data(trk), .clr(cmd_clear),
    .rd_addr(rd_addr), .rd_data(rd_data), .count(count), .full_flag(full)
  );

  cdseq_lfsr #(.LW(LW)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  cdseq_pick #(.TW(TW), .LW(LW)) u_pick (
    .rnd(rnd), .ntracks(disc_tracks), .cur(trk), .pick(pick)
  );

  // transport and track selection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= XP_STOP;
      trk  <= TW'(1);
      pidx <= '0;
    end else begin
      if (cmd_stop) begin
        st <= XP_STOP;
      end else if (cmd_play) begin
        case (st)
          XP_STOP: if (disc_tracks != '0) begin
            st <= XP_PLAY;
            if (rnd_on) trk <= pick;
            else if (prog_on) begin
              trk  <= rd_data[0];
              pidx <= '0;
            end
          end
          XP_PLAY: st <= XP_PAUSE;
          default: st <= XP_PLAY;
        endcase
      end else if (cmd_next) begin
        if (loaded && rnd_on) trk <= pick;
        else if (loaded && prog_on) begin
          pidx <= pidx_inc;
          trk  <= rd_data[1];
        end else trk <= disc_inc;
      end else if (cmd_prev) begin
        if (loaded && rnd_on) trk <= trk;
        else if (loaded && prog_on) begin
          pidx <= pidx_dec;
          trk  <= rd_data[2];
        end else trk <= disc_dec;
      end else if (track_end && st == XP_PLAY) begin
        if (rpt == RP_ONE) trk <= trk;
        else if (rnd_on) trk <= pick;
        else if (prog_on) begin
          if (pidx != last_idx) begin
            pidx <= pidx_inc;
            trk  <= rd_data[1];
          end else if (rpt == RP_ALL) begin
            pidx <= '0;
            trk  <= rd_data[0];
          end else begin
            st   <= XP_STOP;
            pidx <= '0;
            trk  <= TW'(1);
          end
        end else if (trk >= disc_tracks) begin
          trk <= TW'(1);
          if (rpt != RP_ALL) st <= XP_STOP;
        end else trk <= trk + TW'(1);
      end
      if (cmd_clear) pidx <= '0;
    end
  end

  // mode registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt    <= RP_OFF;
      rnd_on <= 1'b0;
    end else begin
      if (cmd_repeat) begin
        case (rpt)
          RP_OFF:  rpt <= RP_ONE;
          RP_ONE:  rpt <= RP_ALL;
          default: rpt <= RP_OFF;
        endcase
      end
      if (cmd_random) rnd_on <= ~rnd_on;
    end
  end

  assign req_track    = trk;
  assign xport_state  = st;
  assign ind_play     = (st == XP_PLAY);
  assign ind_prog     = prog_on;
  assign ind_rpt_one  = (rpt == RP_ONE);
  assign ind_rpt_all  = (rpt == RP_ALL);
  assign ind_random_n = ~rnd_on;
  assign prog_full    = full;
  assign scan_fwd     = loaded && hold_fwd && !hold_rev;
  assign scan_rev     = loaded && hold_rev && !hold_fwd;
endmodule

// File: rtl/cdseq_checker.sv
module cdseq_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_play,
  input logic          cmd_stop,
  input logic          cmd_next,
  input logic          cmd_prev,
  input logic          cmd_repeat,
  input logic          cmd_prog,
  input logic          cmd_clear,
  input logic          cmd_random,
  input logic          hold_fwd,
  input logic          hold_rev,
  input logic          track_end,
  input logic [TW-1:0] disc_tracks,
  input logic [TW-1:0] req_track,
  input logic [1:0]    xport_state,
  input logic          ind_play,
  input logic          ind_prog,
  input logic          ind_rpt_one,
  input logic          ind_rpt_all,
  input logic          ind_random_n,
  input logic          prog_full,
  input logic          scan_fwd,
  input logic          scan_rev
);
  logic steer;
  assign steer = cmd_play | cmd_stop | cmd_next | cmd_prev;

  p_stop_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> xport_state == 2'b00);

  p_end_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (track_end && !steer && xport_state == 2'b10) |=> ($stable(req_track) && xport_state == 2'b10));

  p_repeat_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (track_end && !steer && ind_rpt_one && xport_state == 2'b01) |=> ($stable(req_track) && xport_state == 2'b01));

  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_full && !cmd_clear) |=> prog_full);

  p_random_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_random |=> ind_random_n != $past(ind_random_n));

  p_random_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ind_random_n && xport_state == 2'b01 && disc_tracks != '0) |->
      (req_track >= TW'(1) && req_track <= disc_tracks));

  p_scan_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xport_state == 2'b00) |-> !(scan_fwd || scan_rev));

  p_play_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ind_play) |-> $past(cmd_play));
endmodule

bind cd_mode_sequencer cdseq_checker #(.TW(TW)) chk (.*);

// File: tb/tb_cd_mode_sequencer.sv
module tb_cd_mode_sequencer;
  localparam int TW = 8;
  localparam int C_PLAY = 0, C_STOP = 1, C_NEXT = 2, C_PREV = 3, C_RPT = 4,
                 C_PROG = 5, C_CLR = 6, C_RND = 7, C_END = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_play = 0, cmd_stop = 0, cmd_next = 0, cmd_prev = 0;
  logic cmd_repeat = 0, cmd_prog = 0, cmd_clear = 0, cmd_random = 0;
  logic hold_fwd = 0, hold_rev = 0, track_end = 0;
  logic [TW-1:0] disc_tracks = 8'd5;
  logic [TW-1:0] req_track;
  logic [1:0] xport_state;
  logic ind_play, ind_prog, ind_rpt_one, ind_rpt_all, ind_random_n, prog_full;
  logic scan_fwd, scan_rev;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cd_mode_sequencer #(.TW(TW)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input int c);
    case (c)
      C_PLAY: cmd_play = 1;
      C_STOP: cmd_stop = 1;
      C_NEXT: cmd_next = 1;
      C_PREV: cmd_prev = 1;
      C_RPT:  cmd_repeat = 1;
      C_PROG: cmd_prog = 1;
      C_CLR:  cmd_clear = 1;
      C_RND:  cmd_random = 1;
      default: track_end = 1;
    endcase
    @(negedge clk);
    {cmd_play, cmd_stop, cmd_next, cmd_prev, cmd_repeat, cmd_prog, cmd_clear, cmd_random, track_end} = '0;
  endtask

  task automatic t_reset;
    chk("R1 state", xport_state, 0);
    chk("R1 track", req_track, 1);
    chk("R1 flags", {ind_play, ind_prog, ind_rpt_one, ind_rpt_all, prog_full}, 0);
    chk("R1 random_n", ind_random_n, 1);
  endtask

  task automatic t_select;
    press(C_NEXT); press(C_NEXT);
    chk("R4 next x2", req_track, 3);
    press(C_PREV); press(C_PREV); press(C_PREV);
    chk("R4 prev wrap", req_track, 5);
  endtask

  task automatic t_transport;
    press(C_PLAY);
    chk("R2 play state", xport_state, 1);
    chk("R2 play flag", ind_play, 1);
    chk("R2 track kept", req_track, 5);
    press(C_PLAY);
    chk("R2 pause", xport_state, 2);
    press(C_END);
    chk("R5 end ignored in pause track", req_track, 5);
    chk("R5 end ignored in pause state", xport_state, 2);
    press(C_PLAY);
    chk("R2 resume", xport_state, 1);
    hold_fwd = 1; #1;
    chk("R10 scan fwd", {scan_fwd, scan_rev}, 2);
    hold_rev = 1; #1;
    chk("R10 both held", {scan_fwd, scan_rev}, 0);
    hold_fwd = 0; #1;
    chk("R10 scan rev", {scan_fwd, scan_rev}, 1);
    hold_rev = 0;
  endtask

  task automatic t_end;
    press(C_END);
    chk("R5 last track stops", xport_state, 0);
    chk("R5 last track to 1", req_track, 1);
    hold_fwd = 1; #1;
    chk("R10 no scan in stop", scan_fwd, 0);
    hold_fwd = 0;
    press(C_PLAY);
    press(C_END);
    chk("R5 advance", req_track, 2);
    chk("R5 still playing", xport_state, 1);
  endtask

  task automatic t_repeat;
    press(C_RPT);
    chk("R6 one flag", {ind_rpt_one, ind_rpt_all}, 2);
    press(C_END);
    chk("R6 single repeat holds", req_track, 2);
    press(C_RPT);
    chk("R6 all flag", {ind_rpt_one, ind_rpt_all}, 1);
    press(C_NEXT); press(C_NEXT); press(C_NEXT);
    chk("R4 next in play", req_track, 5);
    press(C_END);
    chk("R6 disc wrap track", req_track, 1);
    chk("R6 disc wrap state", xport_state, 1);
    press(C_RPT);
    chk("R6 off", {ind_rpt_one, ind_rpt_all}, 0);
  endtask

  task automatic t_stop;
    press(C_NEXT); press(C_NEXT);
    press(C_PLAY);
    press(C_STOP);
    chk("R3 stop state", xport_state, 0);
    chk("R3 track kept", req_track, 3);
  endtask

  task automatic t_program;
    press(C_PROG);                       // 3
    press(C_PREV); press(C_PREV);
    press(C_PROG);                       // 1
    press(C_NEXT); press(C_NEXT); press(C_NEXT);
    press(C_PROG);                       // 4
    chk("R7 list indicator", ind_prog, 1);
    press(C_PLAY);
    chk("R8 first entry", req_track, 3);
    press(C_NEXT);
    chk("R8 next entry", req_track, 1);
    press(C_END);
    chk("R8 end to entry three", req_track, 4);
    press(C_END);
    chk("R8 list end stop", xport_state, 0);
    chk("R8 list end track", req_track, 1);
    press(C_STOP);
    chk("R3 stop keeps list", ind_prog, 1);
    press(C_RPT); press(C_RPT);
    press(C_PLAY);
    press(C_PREV);
    chk("R8 prev wraps list", req_track, 4);
    press(C_END);
    chk("R8 repeat all to first entry", req_track, 3);
    chk("R8 repeat all playing", xport_state, 1);
    press(C_STOP);
    press(C_RPT);
  endtask

  task automatic t_full;
    press(C_CLR);
    chk("R7 clear", ind_prog, 0);
    for (int i = 0; i < 16; i++) press(C_PROG);
    chk("R7 sixteen fit", prog_full, 0);
    press(C_PROG);
    chk("R7 seventeenth flagged", prog_full, 1);
    press(C_NEXT);
    press(C_PLAY);
    chk("R7 list intact", req_track, 3);
    press(C_STOP);
    chk("R7 flag sticky", prog_full, 1);
    press(C_CLR);
    chk("R7 clear drops flag", {ind_prog, prog_full}, 0);
  endtask

  task automatic t_random;
    press(C_RND);
    chk("R9 indicator low", ind_random_n, 0);
    press(C_PLAY);
    for (int i = 0; i < 20; i++) begin
      press(C_END);
      chk("R9 never stops", xport_state, 1);
      chk("R9 in range", int'(req_track >= 1 && req_track <= 5), 1);
    end
    press(C_STOP);
    disc_tracks = 8'd1;
    press(C_PLAY);
    chk("R9 one-track disc", req_track, 1);
    press(C_END);
    chk("R9 one-track repeat", req_track, 1);
    press(C_STOP);
    disc_tracks = 8'd5;
    press(C_RND);
    chk("R9 indicator high", ind_random_n, 1);
  endtask

  task automatic t_zero;
    disc_tracks = 8'd0;
    press(C_PLAY);
    chk("R2 empty disc ignored", xport_state, 0);
    disc_tracks = 8'd5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_select();
    t_transport();
    t_end();
    t_repeat();
    t_stop();
    t_program();
    t_full();
    t_random();
    t_zero();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule